// File: doc/BRIEF.md
# Host-to-Processor Command Mailbox

This block is a word-addressed register slave placed between a host bus and an embedded audio processor. The host posts command vectors and data words into single-entry slots. The processor takes them through a valid/take pair. The processor can also hand one word back to the host, drive three general flag bits and request an interrupt. The block presents all of this state to the host in one status register.

Commands that need confirmation use a handshake word. The host arms it by writing zero. The processor completes it by writing any nonzero value. A cycle-counted watchdog, sized from a clocks-per-microsecond parameter and a timeout in microseconds, sets a sticky timeout flag when the processor does not answer in time. Two vector codes have special meaning. The acknowledge code is consumed locally and releases the interrupt. The reset code flushes the mailbox and is still forwarded to the processor.

Register offsets (word addresses): 0 handshake word, 4 control, 5 status, 6 vector, 7 data. Status bits: 1 host data slot empty, 2 return word waiting, 5:3 processor flags, 6 interrupt pending, 7 sticky overrun, 8 sticky timeout, 9 handshake armed. Writing 1 to status bit 7 or bit 8 clears that bit.

Top module: `dsp_cmd_mailbox`

## Requirements
- R1: After reset the status register reads 0x2, the vector register reads 0, irq is low and no vector or data word is offered to the processor.
- R2: A vector write at offset 6 while idle is offered on dsp_vec_valid/dsp_vec_code. It is held unchanged until dsp_vec_take. Reading offset 6 returns the code with bit 0 replaced by the busy flag, which is 1 until the take.
- R3: A vector write while busy is ignored, and the code on offer is unchanged. It sets sticky status bit 7. Writing 1 to status bit 7 clears it.
- R4: A vector write of ACK_CODE (default 0x80F5) is never forwarded and does not set busy.
- R5: A dsp_irq_set pulse sets irq and status bit 6. These stay set until an ACK_CODE write. When the set and the acknowledge fall in the same cycle, irq stays set.
- R6: A host write at offset 7 while status bit 1 is 1 is offered on dsp_dat_valid/dsp_dat_word and clears bit 1. dsp_dat_take sets bit 1 again. A write while bit 1 is 0 is ignored and sets status bit 7.
- R7: dsp_rsp_word is captured when dsp_rsp_valid is high and dsp_rsp_ready is high. The capture sets status bit 2 and drops dsp_rsp_ready. A host read of offset 7 returns the word and frees the slot. A push while full is ignored.
- R8: Status bits 5:3 follow dsp_hflags.
- R9: A host write of zero at offset 0 sets status bit 9. A nonzero dsp_hs_word written with dsp_hs_we completes the handshake: it clears bit 9, and offset 0 then reads that word.
- R10: When an armed handshake is not completed within CYC_PER_US*TIMEOUT_US cycles of the arming write, sticky status bit 8 is set. A completion in the expiry cycle wins. Writing 1 to status bit 8 clears it.
- R11: Writing RST_CODE (default 0x80FF) while idle empties the data slot and the return slot, clears status bits 7 and 8, and is forwarded as a normal vector.
- R12: A host write at offset 4 is stored, driven on dsp_ctl and read back at offset 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_en | input | 1 | Host access strobe |
| host_we | input | 1 | 1 write, 0 read |
| host_addr | input | AW | Word offset |
| host_wdata | input | DW | Write data |
| host_rdata | output | DW | Read data, combinational on host_addr |
| irq | output | 1 | Interrupt to host |
| dsp_ctl | output | DW | Control register contents |
| dsp_vec_valid | output | 1 | Vector on offer |
| dsp_vec_code | output | DW | Offered vector code |
| dsp_vec_take | input | 1 | Processor takes the vector |
| dsp_dat_valid | output | 1 | Data word on offer |
| dsp_dat_word | output | DW | Offered data word |
| dsp_dat_take | input | 1 | Processor takes the data word |
| dsp_rsp_valid | input | 1 | Processor pushes a return word |
| dsp_rsp_word | input | DW | Return word |
| dsp_rsp_ready | output | 1 | Return slot free |
| dsp_hflags | input | 3 | General flags shown in status |
| dsp_irq_set | input | 1 | Interrupt request pulse |
| dsp_hs_we | input | 1 | Processor writes the handshake word |
| dsp_hs_word | input | DW | Handshake value |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is the interrupt request and the host acknowledge. The bench drives dsp_irq_set high in the same cycle as an ACK_CODE vector write. It then expects irq still high, and expects a second acknowledge to release it.

The second pair is handshake completion and watchdog expiry. The bench arms the handshake and waits one cycle short of the limit, which establishes the cycle before expiry. It then drives a nonzero completion into exactly the expiry edge. It judges the outcome by the timeout bit staying clear and the handshake word reading the completion value.

// File: rtl/dsp_mbx_pkg.sv
package dsp_mbx_pkg;
   localparam int unsigned OFS_HS   = 0;
   localparam int unsigned OFS_CTL  = 4;
   localparam int unsigned OFS_STAT = 5;
   localparam int unsigned OFS_VEC  = 6;
   localparam int unsigned OFS_DAT  = 7;

   localparam int unsigned ST_WR_EMPTY = 1;
   localparam int unsigned ST_RD_FULL  = 2;
   localparam int unsigned ST_HF_LO    = 3;
   localparam int unsigned HF_W        = 3;
   localparam int unsigned ST_IRQ      = 6;
   localparam int unsigned ST_OVR      = 7;
   localparam int unsigned ST_TMO      = 8;
   localparam int unsigned ST_ARMED    = 9;
   localparam int unsigned ST_TOP      = ST_ARMED;
endpackage

// File: rtl/mbx_slot.sv
module mbx_slot #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         take,
   output logic         valid,
   output logic [W-1:0] dout
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         dout  <= '0;
      end else if (flush) begin
         valid <= 1'b0;
      end else if (valid) begin
         if (take) valid <= 1'b0;
      end else if (load) begin
         valid <= 1'b1;
         dout  <= din;
      end
   end
endmodule

// File: rtl/mbx_hs_watchdog.sv
module mbx_hs_watchdog #(
   parameter int unsigned DW    = 32,
   parameter int unsigned LIMIT = 5000000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_wr,
   input  logic [DW-1:0] host_wdata,
   input  logic          dsp_we,
   input  logic [DW-1:0] dsp_word,
   input  logic          clr_tmo,
   output logic [DW-1:0] word,
   output logic          armed,
   output logic          timeout
);
   localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;
   logic          done;
   logic          expire;

   assign done   = dsp_we && (dsp_word != '0);
   assign expire = armed && !host_wr && !done && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word  <= '0;
         armed <= 1'b0;
         cnt   <= '0;
      end else if (host_wr) begin
         word  <= host_wdata;
         armed <= (host_wdata == '0);
         cnt   <= '0;
      end else if (done) begin
         word  <= dsp_word;
         armed <= 1'b0;
      end else if (expire) begin
         armed <= 1'b0;
      end else if (armed) begin
         cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) timeout <= 1'b0;
      else        timeout <= (timeout && !clr_tmo) || expire;
   end
endmodule

// File: rtl/dsp_cmd_mailbox.sv
module dsp_cmd_mailbox
   import dsp_mbx_pkg::*;
#(
   parameter int unsigned DW         = 32,
   parameter int unsigned AW         = 4,
   parameter int unsigned CYC_PER_US = 250,
   parameter int unsigned TIMEOUT_US = 20000,
   parameter logic [31:0] ACK_CODE   = 32'h0000_80F5,
   parameter logic [31:0] RST_CODE   = 32'h0000_80FF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            host_en,
   input  logic            host_we,
   input  logic [AW-1:0]   host_addr,
   input  logic [DW-1:0]   host_wdata,
   output logic [DW-1:0]   host_rdata,
   output logic            irq,
   output logic [DW-1:0]   dsp_ctl,
   output logic            dsp_vec_valid,
   output logic [DW-1:0]   dsp_vec_code,
   input  logic            dsp_vec_take,
   output logic            dsp_dat_valid,
   output logic [DW-1:0]   dsp_dat_word,
   input  logic            dsp_dat_take,
   input  logic            dsp_rsp_valid,
   input  logic [DW-1:0]   dsp_rsp_word,
   output logic            dsp_rsp_ready,
   input  logic [HF_W-1:0] dsp_hflags,
   input  logic            dsp_irq_set,
   input  logic            dsp_hs_we,
   input  logic [DW-1:0]   dsp_hs_word
);
   localparam int unsigned LIMIT = CYC_PER_US * TIMEOUT_US;
   localparam logic [DW-1:0] ACK_W = DW'(ACK_CODE);
   localparam logic [DW-1:0] RST_W = DW'(RST_CODE);

   if (AW < 3) begin : g_bad_aw
      $error("AW must reach offset 7");
   end
   if (DW <= ST_TOP) begin : g_bad_dw
      $error("DW must hold all status bits");
   end
   if (LIMIT < 2) begin : g_bad_limit
      $error("handshake limit must be at least 2 cycles");
   end

   logic wr, rd;
   logic wr_vec, vec_ack, vec_load, vec_ovr, rst_cmd;
   logic wr_dat, dat_ovr, rsp_pop, rsp_full;
   logic st_wr, hs_wr;
   logic ovr_q, irq_q;
   logic [DW-1:0] ctl_q, rsp_q, hs_word, stat;
   logic hs_armed, hs_tmo;

   assign wr       = host_en && host_we;
   assign rd       = host_en && !host_we;
   assign wr_vec   = wr && (host_addr == AW'(OFS_VEC));
   assign vec_ack  = wr_vec && (host_wdata == ACK_W);
   assign vec_load = wr_vec && !vec_ack && !dsp_vec_valid;
   assign vec_ovr  = wr_vec && !vec_ack && dsp_vec_valid;
   assign rst_cmd  = vec_load && (host_wdata == RST_W);
   assign wr_dat   = wr && (host_addr == AW'(OFS_DAT));
   assign dat_ovr  = wr_dat && dsp_dat_valid;
   assign rsp_pop  = rd && (host_addr == AW'(OFS_DAT)) && rsp_full;
   assign st_wr    = wr && (host_addr == AW'(OFS_STAT));
   assign hs_wr    = wr && (host_addr == AW'(OFS_HS));

   mbx_slot #(.W(DW)) i_vec_slot (
      .clk(clk), .rst_n(rst_n), .flush(1'b0), .load(vec_load),
      .din(host_wdata), .take(dsp_vec_take),
      .valid(dsp_vec_valid), .dout(dsp_vec_code)
   );

   mbx_slot #(.W(DW)) i_dat_slot (
      .clk(clk), .rst_n(rst_n), .flush(rst_cmd), .load(wr_dat),
      .din(host_wdata), .take(dsp_dat_take),
      .valid(dsp_dat_valid), .dout(dsp_dat_word)
   );

   mbx_slot #(.W(DW)) i_rsp_slot (
      .clk(clk), .rst_n(rst_n), .flush(rst_cmd), .load(dsp_rsp_valid),
      .din(dsp_rsp_word), .take(rsp_pop),
      .valid(rsp_full), .dout(rsp_q)
   );

   assign dsp_rsp_ready = !rsp_full;

   mbx_hs_watchdog #(.DW(DW), .LIMIT(LIMIT)) i_hs_wdog (
      .clk(clk), .rst_n(rst_n),
      .host_wr(hs_wr), .host_wdata(host_wdata),
      .dsp_we(dsp_hs_we), .dsp_word(dsp_hs_word),
      .clr_tmo(rst_cmd || (st_wr && host_wdata[ST_TMO])),
      .word(hs_word), .armed(hs_armed), .timeout(hs_tmo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
         irq_q <= 1'b0;
         ctl_q <= '0;
      end else begin
         if (rst_cmd) ovr_q <= 1'b0;
         else ovr_q <= (ovr_q && !(st_wr && host_wdata[ST_OVR])) || vec_ovr || dat_ovr;
         irq_q <= dsp_irq_set || (irq_q && !vec_ack);
         if (wr && (host_addr == AW'(OFS_CTL))) ctl_q <= host_wdata;
      end
   end

   assign irq     = irq_q;
   assign dsp_ctl = ctl_q;

   always_comb begin
      stat = '0;
      stat[ST_WR_EMPTY]              = !dsp_dat_valid;
      stat[ST_RD_FULL]               = rsp_full;
      stat[ST_HF_LO +: HF_W]         = dsp_hflags;
      stat[ST_IRQ]                   = irq_q;
      stat[ST_OVR]                   = ovr_q;
      stat[ST_TMO]                   = hs_tmo;
      stat[ST_ARMED]                 = hs_armed;
   end

   always_comb begin
      host_rdata = '0;
      if (host_addr == AW'(OFS_HS))        host_rdata = hs_word;
      else if (host_addr == AW'(OFS_CTL))  host_rdata = ctl_q;
      else if (host_addr == AW'(OFS_STAT)) host_rdata = stat;
      else if (host_addr == AW'(OFS_VEC))  host_rdata = {dsp_vec_code[DW-1:1], dsp_vec_valid};
      else if (host_addr == AW'(OFS_DAT))  host_rdata = rsp_q;
   end
endmodule

// File: rtl/dsp_cmd_mailbox_chk.sv
module dsp_cmd_mailbox_chk
   import dsp_mbx_pkg::*;
#(
   parameter int unsigned DW       = 32,
   parameter int unsigned AW       = 4,
   parameter logic [31:0] ACK_CODE = 32'h0000_80F5,
   parameter logic [31:0] RST_CODE = 32'h0000_80FF
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_en,
   input logic          host_we,
   input logic [AW-1:0] host_addr,
   input logic [DW-1:0] host_wdata,
   input logic          irq,
   input logic          dsp_vec_valid,
   input logic [DW-1:0] dsp_vec_code,
   input logic          dsp_vec_take,
   input logic          dsp_dat_valid,
   input logic [DW-1:0] dsp_dat_word,
   input logic          dsp_dat_take,
   input logic          dsp_rsp_ready,
   input logic          dsp_irq_set
);
   logic vec_wr, ack_wr, rst_wr, dat_rd;
   assign vec_wr = host_en && host_we && (host_addr == AW'(OFS_VEC));
   assign ack_wr = vec_wr && (host_wdata == DW'(ACK_CODE));
   assign rst_wr = vec_wr && (host_wdata == DW'(RST_CODE)) && !dsp_vec_valid;
   assign dat_rd = host_en && !host_we && (host_addr == AW'(OFS_DAT));

   // R2
   vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_vec_valid && !dsp_vec_take |=> dsp_vec_valid && $stable(dsp_vec_code));
   // R4
   ack_no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr && !dsp_vec_valid |=> !dsp_vec_valid);
   // R5
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !ack_wr |=> irq);
   // R5
   irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_irq_set |=> irq);
   // R6
   dat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_dat_valid && !dsp_dat_take && !rst_wr |=> dsp_dat_valid && $stable(dsp_dat_word));
   // R7
   rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dsp_rsp_ready && !dat_rd && !rst_wr |=> !dsp_rsp_ready);
endmodule

bind dsp_cmd_mailbox dsp_cmd_mailbox_chk #(
   .DW(DW), .AW(AW), .ACK_CODE(ACK_CODE), .RST_CODE(RST_CODE)
) i_dsp_cmd_mailbox_chk (
   .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
   .host_addr(host_addr), .host_wdata(host_wdata), .irq(irq),
   .dsp_vec_valid(dsp_vec_valid), .dsp_vec_code(dsp_vec_code),
   .dsp_vec_take(dsp_vec_take), .dsp_dat_valid(dsp_dat_valid),
   .dsp_dat_word(dsp_dat_word), .dsp_dat_take(dsp_dat_take),
   .dsp_rsp_ready(dsp_rsp_ready), .dsp_irq_set(dsp_irq_set)
);

// File: tb/test_dsp_cmd_mailbox.sv
`timescale 1ns/1ps
module test_dsp_cmd_mailbox;
   localparam int unsigned DW = 32;
   localparam int unsigned AW = 4;
   localparam int unsigned CPU = 5;
   localparam int unsigned TUS = 4;
   localparam int unsigned LIM = CPU * TUS;
   localparam logic [31:0] ACK = 32'h80F5;
   localparam logic [31:0] RST = 32'h80FF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_en = 1'b0, host_we = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0, host_rdata;
   logic irq;
   logic [DW-1:0] dsp_ctl, dsp_vec_code, dsp_dat_word;
   logic dsp_vec_valid, dsp_dat_valid, dsp_rsp_ready;
   logic dsp_vec_take = 1'b0, dsp_dat_take = 1'b0, dsp_rsp_valid = 1'b0;
   logic [DW-1:0] dsp_rsp_word = '0, dsp_hs_word = '0;
   logic [2:0] dsp_hflags = '0;
   logic dsp_irq_set = 1'b0, dsp_hs_we = 1'b0;

   int total = 0, bad = 0;
   logic [DW-1:0] exp_q[$];

   always #2 clk = ~clk;

   dsp_cmd_mailbox #(.DW(DW), .AW(AW), .CYC_PER_US(CPU), .TIMEOUT_US(TUS),
                     .ACK_CODE(ACK), .RST_CODE(RST)) i_dsp_cmd_mailbox (
      .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .irq(irq), .dsp_ctl(dsp_ctl), .dsp_vec_valid(dsp_vec_valid),
      .dsp_vec_code(dsp_vec_code), .dsp_vec_take(dsp_vec_take),
      .dsp_dat_valid(dsp_dat_valid), .dsp_dat_word(dsp_dat_word),
      .dsp_dat_take(dsp_dat_take), .dsp_rsp_valid(dsp_rsp_valid),
      .dsp_rsp_word(dsp_rsp_word), .dsp_rsp_ready(dsp_rsp_ready),
      .dsp_hflags(dsp_hflags), .dsp_irq_set(dsp_irq_set),
      .dsp_hs_we(dsp_hs_we), .dsp_hs_word(dsp_hs_word)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hwrite(input int unsigned a, input logic [DW-1:0] d);
      @(negedge clk);
      host_en = 1'b1; host_we = 1'b1; host_addr = AW'(a); host_wdata = d;
      @(negedge clk);
      host_en = 1'b0; host_we = 1'b0;
   endtask

   task automatic hread(input int unsigned a, output logic [DW-1:0] d);
      @(negedge clk);
      host_en = 1'b1; host_we = 1'b0; host_addr = AW'(a);
      #1 d = host_rdata;
      @(negedge clk);
      host_en = 1'b0;
   endtask

   task automatic peek(input int unsigned a, output logic [DW-1:0] d);
      host_addr = AW'(a);
      #1 d = host_rdata;
   endtask

   task automatic send_vec(input logic [DW-1:0] code, input bit expect_fwd);
      if (expect_fwd) exp_q.push_back(code);
      hwrite(6, code);
   endtask

   task automatic take_vec();
      @(negedge clk); dsp_vec_take = 1'b1;
      @(negedge clk); dsp_vec_take = 1'b0;
   endtask

   // scoreboard monitor: every vector the processor takes must be the next expected
   always @(negedge clk) begin
      #2;
      if (rst_n && dsp_vec_valid && dsp_vec_take) begin
         if (exp_q.size() == 0) chk("R2 unexpected vector", dsp_vec_code, '1);
         else chk("R2 vector delivery", dsp_vec_code, exp_q.pop_front());
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [DW-1:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1
      hread(5, d); chk("R1 status", d, 32'h2);
      hread(6, d); chk("R1 vector", d, 32'h0);
      chk("R1 irq", DW'(irq), 0);
      chk("R1 offers", DW'({dsp_vec_valid, dsp_dat_valid}), 0);

      // R2
      send_vec(32'h00E3, 1);
      chk("R2 offered", DW'(dsp_vec_valid), 1);
      chk("R2 code", dsp_vec_code, 32'h00E3);
      hread(6, d); chk("R2 busy read", d, 32'h00E3);
      take_vec();
      hread(6, d); chk("R2 idle read", d, 32'h00E2);

      // R3
      send_vec(32'h00DD, 1);
      send_vec(32'h00DF, 0);
      chk("R3 code kept", dsp_vec_code, 32'h00DD);
      hread(5, d); chk("R3 overrun", d, 32'h82);
      take_vec();
      hwrite(5, 32'h80);
      hread(5, d); chk("R3 w1c", d, 32'h2);

      // R5 / R4
      @(negedge clk); dsp_irq_set = 1'b1;
      @(negedge clk); dsp_irq_set = 1'b0;
      chk("R5 irq", DW'(irq), 1);
      peek(5, d); chk("R5 status", d, 32'h42);
      send_vec(ACK, 0);
      chk("R4 ack clears irq", DW'(irq), 0);
      chk("R4 not forwarded", DW'(dsp_vec_valid), 0);
      @(negedge clk);
      dsp_irq_set = 1'b1; host_en = 1'b1; host_we = 1'b1; host_addr = 4'd6; host_wdata = ACK;
      @(negedge clk);
      dsp_irq_set = 1'b0; host_en = 1'b0; host_we = 1'b0;
      chk("R5 set beats ack", DW'(irq), 1);
      send_vec(ACK, 0);
      chk("R5 second ack", DW'(irq), 0);

      // R6
      hwrite(7, 32'h1234);
      chk("R6 offered", DW'(dsp_dat_valid), 1);
      peek(5, d); chk("R6 not empty", d, 32'h0);
      hwrite(7, 32'h5678);
      chk("R6 word kept", dsp_dat_word, 32'h1234);
      peek(5, d); chk("R6 overrun", d, 32'h80);
      @(negedge clk); dsp_dat_take = 1'b1;
      @(negedge clk); dsp_dat_take = 1'b0;
      peek(5, d); chk("R6 taken", d, 32'h82);
      hwrite(5, 32'h80);

      // R7
      @(negedge clk); dsp_rsp_valid = 1'b1; dsp_rsp_word = 32'hCAFE;
      @(negedge clk); dsp_rsp_word = 32'hBEEF;
      chk("R7 ready low", DW'(dsp_rsp_ready), 0);
      @(negedge clk); dsp_rsp_valid = 1'b0;
      peek(5, d); chk("R7 full", d, 32'h6);
      hread(7, d); chk("R7 word", d, 32'hCAFE);
      peek(5, d); chk("R7 freed", d, 32'h2);
      chk("R7 ready high", DW'(dsp_rsp_ready), 1);

      // R8
      dsp_hflags = 3'b101;
      peek(5, d); chk("R8 flags", d, 32'h2A);
      dsp_hflags = 3'b000;

      // R12
      hwrite(4, 32'hA5A5);
      chk("R12 ctl out", dsp_ctl, 32'hA5A5);
      hread(4, d); chk("R12 ctl read", d, 32'hA5A5);

      // R9
      hwrite(0, 0);
      peek(5, d); chk("R9 armed", d, 32'h202);
      repeat (3) @(negedge clk);
      dsp_hs_we = 1'b1; dsp_hs_word = 32'h1;
      @(negedge clk); dsp_hs_we = 1'b0;
      peek(5, d); chk("R9 done", d, 32'h2);
      peek(0, d); chk("R9 word", d, 32'h1);

      // R10 expiry
      hwrite(0, 0);
      repeat (LIM - 1) @(negedge clk);
      peek(5, d); chk("R10 before limit", d, 32'h202);
      @(negedge clk);
      peek(5, d); chk("R10 timeout", d, 32'h102);
      hwrite(5, 32'h100);
      peek(5, d); chk("R10 w1c", d, 32'h2);
      // R10 completion at the expiry edge
      hwrite(0, 0);
      repeat (LIM - 1) @(negedge clk);
      dsp_hs_we = 1'b1; dsp_hs_word = 32'h7;
      @(negedge clk); dsp_hs_we = 1'b0;
      peek(5, d); chk("R10 completion wins", d, 32'h2);
      peek(0, d); chk("R10 word", d, 32'h7);

      // R11
      hwrite(7, 32'h11);
      @(negedge clk); dsp_rsp_valid = 1'b1; dsp_rsp_word = 32'h22;
      @(negedge clk); dsp_rsp_valid = 1'b0;
      hwrite(7, 32'h33);
      peek(5, d); chk("R11 before", d, 32'h84);
      send_vec(RST, 1);
      peek(5, d); chk("R11 flushed", d, 32'h2);
      chk("R11 forwarded", dsp_vec_code, RST);
      take_vec();

      @(negedge clk);
      chk("R2 scoreboard empty", DW'(exp_q.size()), 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule